// File: doc/BRIEF.md
# Weight-Reuse Convolution Lane

This block is one compute lane of a convolution engine. It takes a set of weights from a weight stream and a block of input features from a feature stream, and stores both in a local buffer. It then runs one multiply-accumulate pass for each weight of the set. Every pass combines a single held weight with every feature of the block and emits one accumulated result. One feature block therefore serves several passes. The number of passes per set is the weight-reuse factor. The lane fetches each feature once per set and reads it from the buffer on every later pass.

The buffer has a weight part and a feature part. Each part is built with one bank or two, chosen at compile time. With two weight banks, the next weight set streams in while the current set is being computed, so load time and compute time overlap. With one feature bank, the next feature block can load only after the current set has released the bank, so fetch and compute run one after the other. The reuse factor, the features per pass and the number of sets are runtime inputs. They are captured when the lane leaves idle.

The controller has four states:
- ST_IDLE waits for `start`. The transition ST_IDLE→ST_WAIT captures the configuration.
- ST_WAIT waits until a full weight bank and a full feature bank are both present (ST_WAIT→ST_MAC).
- ST_MAC accumulates one product per cycle. It moves to ST_EMIT after the last feature of the pass (ST_MAC→ST_EMIT).
- ST_EMIT is the single overhead cycle that presents the result. It then goes to ST_MAC for the next pass (ST_EMIT→ST_MAC), to ST_WAIT for the next set (ST_EMIT→ST_WAIT), or to ST_IDLE after the last set (ST_EMIT→ST_IDLE).

Top module: `cnn_lane_ctrl`

## Requirements
- R1: After reset, `res_valid`, `wt_ready` and `ft_ready` are all low.
- R2: `start` is acted on only in idle. `cfg_reuse`, `cfg_feats` and `cfg_sets` are captured at that moment. Changes to them, or further `start` pulses while running, alter neither the results nor their number.
- R3: For set s, result j (j = 0 … NW-1, in that order) equals the sum over i of w[s][j]·f[s][i]. All values are signed two's complement. After NW results for each of the configured sets, the lane returns to idle with both ready outputs low.
- R4: Each set consumes exactly NW words from the weight stream, where word j is the weight of pass j. Each set also consumes exactly NF words from the feature stream, in feature order. Features are fetched once per set and reused by all NW passes.
- R5: Within a set, consecutive `res_valid` pulses are exactly NF+1 cycles apart: NF accumulate cycles plus one overhead cycle. Each pulse lasts one cycle.
- R6: With weight double buffering enabled (default), the weight stream may be accepted (`wt_ready` high) between two results of the same set. The next set therefore loads while the current one computes.
- R7: With feature double buffering disabled (default), `ft_ready` stays low from the first result of a set up to and including its last result.
- R8: Cycles with `wt_valid` or `ft_valid` low delay loading but lose no data and do not change any result.
- R9: A configured reuse factor or feature count of 0 acts as 1. A value above BUF_WORDS/4 acts as BUF_WORDS/4. A set count of 0 acts as 1.
- R10: The accumulator never overflows. With 16 features of value -128, a weight of -128 gives 262144 and a weight of 127 gives -260096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Leave idle and capture the configuration |
| cfg_reuse | input | $clog2(BUF_WORDS/4+1) | Weight-reuse factor NW (passes per set) |
| cfg_feats | input | $clog2(BUF_WORDS/4+1) | Features per pass NF |
| cfg_sets | input | SETS_W | Number of weight sets to process |
| wt_valid | input | 1 | Weight word offered |
| wt_ready | output | 1 | Weight word accepted this cycle if valid |
| wt_data | input | W_W | Signed weight word |
| ft_valid | input | 1 | Feature word offered |
| ft_ready | output | 1 | Feature word accepted this cycle if valid |
| ft_data | input | F_W | Signed feature word |
| res_valid | output | 1 | One-cycle strobe marking a finished pass |
| res_data | output | W_W+F_W+$clog2(BUF_WORDS/4+1) | Signed accumulated result |

## Verification
Dense streams with random data over several sets check result values and ordering. They also check the fixed NF+1 spacing. A configuration with many weights and few features makes the next weight set load while a set computes. That separates a two-bank weight buffer from a one-bank one, and the same run shows that the single feature bank stays closed during compute. Random gaps on both valid inputs separate stall-safe loading from loading that drops or repeats words. Zero and oversized configuration values exercise the clamping. All-minimum operands expose an accumulator that is too narrow. Changing the configuration inputs in mid-run shows whether they are sampled only on leaving idle.

// File: rtl/cnn_lane_pkg.sv
package cnn_lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MAC  = 2'd2,
        ST_EMIT = 2'd3
    } lane_state_e;

    // Limit a requested count to the range 1 .. hi.
    function automatic int clamp_count(input int req, input int hi);
        if (req < 1) return 1;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/lane_bank_loader.sv
module lane_bank_loader #(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int NBANK  = 1,
    parameter int LEN_W  = 5,
    parameter int SETS_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [SETS_W-1:0] sets_in,
    input  logic              s_valid,
    input  logic [DW-1:0]     s_data,
    output logic              s_ready,
    output logic              rd_full,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DW-1:0]     rd_data,
    input  logic              release_bank
);

    localparam int AW = $clog2(NBANK * DEPTH);

    logic [NBANK-1:0]  full;
    logic              wr_bank;
    logic              rd_bank;
    logic [LEN_W-1:0]  wr_idx;
    logic [LEN_W-1:0]  len_q;
    logic [SETS_W-1:0] sets_left;
    logic [DW-1:0]     mem [NBANK*DEPTH];
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic              wr_free;
    logic              accept;
    logic              last_word;

    generate
        if (NBANK > 1) begin : g_dual
            assign wr_addr = {wr_bank, wr_idx[IDX_W-1:0]};
            assign rd_addr = {rd_bank, rd_idx};
        end else begin : g_single
            assign wr_addr = wr_idx[IDX_W-1:0];
            assign rd_addr = rd_idx;
        end
    endgenerate

    assign wr_free   = !full[wr_bank];
    assign rd_full   = full[rd_bank];
    assign s_ready   = (sets_left != '0) && wr_free;
    assign accept    = s_valid && s_ready;
    assign last_word = (wr_idx == len_q - LEN_W'(1));
    assign rd_data   = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_addr] <= s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full      <= '0;
            wr_bank   <= 1'b0;
            rd_bank   <= 1'b0;
            wr_idx    <= '0;
            len_q     <= LEN_W'(1);
            sets_left <= '0;
        end else begin
            if (start) begin
                sets_left <= sets_in;
                len_q     <= len_in;
                wr_idx    <= '0;
            end
            if (accept) begin
                if (last_word) begin
                    wr_idx         <= '0;
                    full[wr_bank]  <= 1'b1;
                    sets_left      <= sets_left - SETS_W'(1);
                    if (NBANK > 1) wr_bank <= !wr_bank;
                end else begin
                    wr_idx <= wr_idx + LEN_W'(1);
                end
            end
            if (release_bank) begin
                full[rd_bank] <= 1'b0;
                if (NBANK > 1) rd_bank <= !rd_bank;
            end
        end
    end

    // R4: the write index never reaches the configured set length
    assert_word_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sets_left != '0) |-> (wr_idx < len_q));

    // R3: the compute side only hands back a bank that holds a complete set
    assert_release_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        release_bank |-> rd_full);

endmodule

// File: rtl/lane_mac.sv
module lane_mac #(
    parameter int W_W   = 8,
    parameter int F_W   = 8,
    parameter int ACC_W = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [W_W-1:0]   w_in,
    input  logic signed [F_W-1:0]   f_in,
    output logic signed [ACC_W-1:0] acc
);

    localparam int PW = W_W + F_W;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_x;

    assign prod   = w_in * f_in;
    assign prod_x = {{(ACC_W-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= (first ? '0 : acc) + prod_x;
        end
    end

    // R10: adding a same-signed product never flips the accumulator sign
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !first && (acc[ACC_W-1] == prod_x[ACC_W-1]))
        |=> (acc[ACC_W-1] == $past(acc[ACC_W-1])));

endmodule

// File: rtl/cnn_lane_ctrl.sv
module cnn_lane_ctrl
    import cnn_lane_pkg::*;
#(
    parameter int W_W       = 8,
    parameter int F_W       = 8,
    parameter int BUF_WORDS = 64,
    parameter int WT_DBL    = 1,
    parameter int FT_DBL    = 0,
    parameter int SETS_W    = 8,
    localparam int MAX_NW   = BUF_WORDS / 4,
    localparam int MAX_NF   = BUF_WORDS / 4,
    localparam int NW_W     = $clog2(MAX_NW + 1),
    localparam int NF_W     = $clog2(MAX_NF + 1),
    localparam int ACC_W    = W_W + F_W + $clog2(MAX_NF + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NW_W-1:0]         cfg_reuse,
    input  logic [NF_W-1:0]         cfg_feats,
    input  logic [SETS_W-1:0]       cfg_sets,
    input  logic                    wt_valid,
    output logic                    wt_ready,
    input  logic signed [W_W-1:0]   wt_data,
    input  logic                    ft_valid,
    output logic                    ft_ready,
    input  logic signed [F_W-1:0]   ft_data,
    output logic                    res_valid,
    output logic signed [ACC_W-1:0] res_data
);

    localparam int WIDX_W = $clog2(MAX_NW);
    localparam int FIDX_W = $clog2(MAX_NF);
    localparam int WBANKS = (WT_DBL != 0) ? 2 : 1;
    localparam int FBANKS = (FT_DBL != 0) ? 2 : 1;

    lane_state_e state, state_nx;

    logic [NW_W-1:0]   nw_q, nw_cl, it_idx;
    logic [NF_W-1:0]   nf_q, nf_cl, k_idx;
    logic [SETS_W-1:0] sets_q, sets_cl;
    logic              go;
    logic              last_feat, last_pass, last_set;
    logic              mac_en, mac_first, rel;
    logic              wt_full, ft_full;
    logic [W_W-1:0]    wt_word;
    logic [F_W-1:0]    ft_word;

    assign nw_cl   = NW_W'(clamp_count(int'(cfg_reuse), MAX_NW));
    assign nf_cl   = NF_W'(clamp_count(int'(cfg_feats), MAX_NF));
    assign sets_cl = SETS_W'(clamp_count(int'(cfg_sets), (1 << SETS_W) - 1));
    assign go      = start && (state == ST_IDLE);

    assign last_feat = (k_idx == nf_q - NF_W'(1));
    assign last_pass = (it_idx == nw_q - NW_W'(1));
    assign last_set  = (sets_q == SETS_W'(1));

    lane_bank_loader #(
        .DW(W_W), .DEPTH(MAX_NW), .NBANK(WBANKS), .LEN_W(NW_W), .SETS_W(SETS_W)
    ) u_wt_buf (
        .clk(clk), .rst_n(rst_n), .start(go), .len_in(nw_cl), .sets_in(sets_cl),
        .s_valid(wt_valid), .s_data(wt_data), .s_ready(wt_ready),
        .rd_full(wt_full), .rd_idx(it_idx[WIDX_W-1:0]), .rd_data(wt_word),
        .release_bank(rel)
    );

    lane_bank_loader #(
        .DW(F_W), .DEPTH(MAX_NF), .NBANK(FBANKS), .LEN_W(NF_W), .SETS_W(SETS_W)
    ) u_ft_buf (
        .clk(clk), .rst_n(rst_n), .start(go), .len_in(nf_cl), .sets_in(sets_cl),
        .s_valid(ft_valid), .s_data(ft_data), .s_ready(ft_ready),
        .rd_full(ft_full), .rd_idx(k_idx[FIDX_W-1:0]), .rd_data(ft_word),
        .release_bank(rel)
    );

    lane_mac #(.W_W(W_W), .F_W(F_W), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
        .w_in(wt_word), .f_in(ft_word), .acc(res_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_WAIT;
            ST_WAIT: if (wt_full && ft_full) state_nx = ST_MAC;
            ST_MAC:  if (last_feat) state_nx = ST_EMIT;
            ST_EMIT: begin
                if (!last_pass)    state_nx = ST_MAC;
                else if (last_set) state_nx = ST_IDLE;
                else               state_nx = ST_WAIT;
            end
        endcase
    end

    // outputs
    always_comb begin
        mac_en    = 1'b0;
        mac_first = 1'b0;
        res_valid = 1'b0;
        rel       = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT: ;
            ST_MAC: begin
                mac_en    = 1'b1;
                mac_first = (k_idx == '0);
            end
            ST_EMIT: begin
                res_valid = 1'b1;
                rel       = last_pass;
            end
        endcase
    end

    // loop counters and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nw_q   <= NW_W'(1);
            nf_q   <= NF_W'(1);
            sets_q <= '0;
            it_idx <= '0;
            k_idx  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    nw_q   <= nw_cl;
                    nf_q   <= nf_cl;
                    sets_q <= sets_cl;
                    it_idx <= '0;
                    k_idx  <= '0;
                end
                ST_WAIT: k_idx <= '0;
                ST_MAC:  k_idx <= last_feat ? '0 : k_idx + NF_W'(1);
                ST_EMIT: begin
                    if (last_pass) begin
                        it_idx <= '0;
                        sets_q <= sets_q - SETS_W'(1);
                    end else begin
                        it_idx <= it_idx + NW_W'(1);
                    end
                end
            endcase
        end
    end

    // R5: a result strobe lasts exactly one cycle
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4: accumulation only runs on complete weight and feature sets
    assert_sets_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAC) |-> (wt_full && ft_full));

    // R2: captured configuration holds while the lane is busy
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(nw_q) && $stable(nf_q)));

    generate
        if (FT_DBL == 0) begin : g_ft_serial
            // R7: a single feature bank never refills while a set computes
            assert_ft_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ((state == ST_MAC) || (state == ST_EMIT)) |-> !ft_ready);
        end
    endgenerate

endmodule

// File: tb/cnn_lane_ctrl_test.sv
module cnn_lane_ctrl_test;

    localparam int W_W   = 8;
    localparam int F_W   = 8;
    localparam int BUFW  = 64;
    localparam int MAXN  = BUFW / 4;
    localparam int CW    = $clog2(MAXN + 1);
    localparam int ACC_W = W_W + F_W + $clog2(MAXN + 1);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic [CW-1:0]           cfg_reuse = '0;
    logic [CW-1:0]           cfg_feats = '0;
    logic [7:0]              cfg_sets = '0;
    logic                    wt_valid = 1'b0;
    logic                    wt_ready;
    logic signed [W_W-1:0]   wt_data = '0;
    logic                    ft_valid = 1'b0;
    logic                    ft_ready;
    logic signed [F_W-1:0]   ft_data = '0;
    logic                    res_valid;
    logic signed [ACC_W-1:0] res_data;

    cnn_lane_ctrl #(.W_W(W_W), .F_W(F_W), .BUF_WORDS(BUFW), .WT_DBL(1), .FT_DBL(0), .SETS_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_reuse(cfg_reuse), .cfg_feats(cfg_feats), .cfg_sets(cfg_sets),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_data(wt_data),
        .ft_valid(ft_valid), .ft_ready(ft_ready), .ft_data(ft_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    always #5 clk = ~clk;

    int wq[$];
    int fq[$];
    int exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_cyc = 0;
    int res_in_set = 0;
    int cur_nw = 1;
    int cur_nf = 1;
    int wacc = 0;
    int facc = 0;
    bit gap_on = 1'b0;
    bit saw_ovl = 1'b0;
    string cur_tag = "R3";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // weight stream driver
    initial begin
        forever begin
            @(negedge clk);
            if (wq.size() > 0 && (!gap_on || $urandom_range(0, 3) != 0)) begin
                wt_valid = 1'b1;
                wt_data  = W_W'(wq[0]);
            end else begin
                wt_valid = 1'b0;
            end
            #4;
            if (wt_valid && wt_ready) begin
                void'(wq.pop_front());
                wacc++;
            end
        end
    end

    // feature stream driver
    initial begin
        forever begin
            @(negedge clk);
            if (fq.size() > 0 && (!gap_on || $urandom_range(0, 2) != 0)) begin
                ft_valid = 1'b1;
                ft_data  = F_W'(fq[0]);
            end else begin
                ft_valid = 1'b0;
            end
            #4;
            if (ft_valid && ft_ready) begin
                void'(fq.pop_front());
                facc++;
            end
        end
    end

    // per-cycle comparison against the reference queue
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (res_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_tag, "unexpected result", int'(res_data), 0);
                    end else begin
                        check(int'(res_data) == exp_q[0], cur_tag, "result value",
                              int'(res_data), exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    if (res_in_set > 0)
                        check(cyc - last_cyc == cur_nf + 1, "R5", "result spacing",
                              cyc - last_cyc, cur_nf + 1);
                    check(!ft_ready, "R7", "feature ready during set", int'(ft_ready), 0);
                    last_cyc = cyc;
                    res_in_set++;
                    if (res_in_set == cur_nw) res_in_set = 0;
                end else if (res_in_set > 0) begin
                    if (ft_ready) check(1'b0, "R7", "feature ready between results", 1, 0);
                    if (wt_ready) saw_ovl = 1'b1;
                end
            end
        end
    end

    function automatic int clampv(input int v, input int hi);
        if (v < 1) return 1;
        if (v > hi) return hi;
        return v;
    endfunction

    // mode 0: random operands, mode 1: extreme operands
    task automatic run_case(input int sets_in, input int nw_in, input int nf_in,
                            input bit gaps, input int mode, input bit poke,
                            input string tag);
        int sets, nw, nf, guard;
        int ws[$];
        int fs[$];
        sets = clampv(sets_in, 255);
        nw   = clampv(nw_in, MAXN);
        nf   = clampv(nf_in, MAXN);
        cur_nw = nw;
        cur_nf = nf;
        cur_tag = tag;
        res_in_set = 0;
        saw_ovl = 1'b0;
        for (int s = 0; s < sets; s++) begin
            for (int j = 0; j < nw; j++)
                ws.push_back(mode == 1 ? (j == 0 ? -128 : 127) : $urandom_range(0, 255) - 128);
            for (int i = 0; i < nf; i++)
                fs.push_back(mode == 1 ? -128 : $urandom_range(0, 255) - 128);
        end
        for (int s = 0; s < sets; s++) begin
            for (int j = 0; j < nw; j++) begin
                int acc;
                acc = 0;
                for (int i = 0; i < nf; i++) acc += ws[s*nw + j] * fs[s*nf + i];
                exp_q.push_back(acc);
            end
        end
        wacc = 0;
        facc = 0;
        gap_on = gaps;
        foreach (ws[k]) wq.push_back(ws[k]);
        foreach (fs[k]) fq.push_back(fs[k]);
        @(negedge clk);
        cfg_reuse = CW'(nw_in);
        cfg_feats = CW'(nf_in);
        cfg_sets  = 8'(sets_in);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            cfg_reuse = CW'(5);
            cfg_feats = CW'(7);
            cfg_sets  = 8'd4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while ((exp_q.size() > 0 || wq.size() > 0 || fq.size() > 0) && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 6000) begin
            check(1'b0, tag, "scenario timed out", exp_q.size(), 0);
            exp_q.delete();
            wq.delete();
            fq.delete();
        end
        repeat (6) @(negedge clk);
        check(wacc == sets * nw, "R4", "weight words consumed", wacc, sets * nw);
        check(facc == sets * nf, "R4", "feature words consumed once", facc, sets * nf);
        check(!wt_ready && !ft_ready && !res_valid, "R3", "idle after last set",
              int'({wt_ready, ft_ready, res_valid}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!res_valid, "R1", "res_valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!res_valid, "R1", "res_valid after reset", int'(res_valid), 0);
        check(!wt_ready, "R1", "wt_ready after reset", int'(wt_ready), 0);
        check(!ft_ready, "R1", "ft_ready after reset", int'(ft_ready), 0);

        run_case(2, 3, 4, 1'b0, 0, 1'b0, "R3");
        run_case(3, 6, 2, 1'b0, 0, 1'b0, "R3");
        check(saw_ovl, "R6", "next weight set loads during compute", int'(saw_ovl), 1);
        run_case(3, 4, 6, 1'b1, 0, 1'b0, "R8");
        run_case(2, 5, 3, 1'b1, 0, 1'b0, "R8");
        run_case(0, 0, 20, 1'b0, 0, 1'b0, "R9");
        run_case(1, 20, 0, 1'b0, 0, 1'b0, "R9");
        run_case(1, 2, 16, 1'b0, 1, 1'b0, "R10");
        run_case(2, 2, 3, 1'b0, 0, 1'b1, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule